// File: doc/BRIEF.md
# DMA Transfer Length Controller

This block controls the byte counter behind one information-transfer phase of a SCSI host adapter. Software loads a 24-bit transfer count one byte at a time. When a transfer starts, the block works out how many bytes the coming DMA burst may move. That number depends on three things: the loaded count, a signed remaining-phase size and whether the adapter is in the command phase. The sign of the remaining size sets the transfer direction.

During the burst, the DMA engine pulses an acknowledge for every byte it moves. The block counts these pulses down. When the burst is used up, it finishes the transfer: it sets a transfer-complete status bit, posts a bus-service interrupt code, clears the sequence step and the FIFO flags, and zeroes the stored count.

There is one exception. If data is coming from the device and some of the phase is still outstanding, the block waits and finishes only when the next data chunk arrives.

Top module: `xfer_len_ctrl`

## Requirements
- R1: The stored count reads back as the low byte, plus the mid byte shifted left by 8, plus the high byte shifted left by 16. The bytes are written through `reg_sel` values 0, 1 and 2. Value 3 writes the sequence step from `reg_wdata[2:0]`. Value 4 writes the FIFO flags from `reg_wdata[4:0]`.
- R2: A stored count of zero is treated as 65536 bytes when the burst length is worked out.
- R3: With `cmd_phase` high at start, the burst length is the smaller of the effective count and 32.
- R4: A negative `rem_size` at start makes `to_device` 1. The burst length is then the smaller of the effective count and the magnitude of `rem_size`.
- R5: A zero or positive `rem_size` at start makes `to_device` 0. The burst length is then the smaller of the effective count and `rem_size`.
- R6: A start while idle clears `stat_tc` and raises `busy` in the next cycle, unless the burst is zero.
- R7: Each `byte_ack` pulse while busy consumes one byte of the burst. `xfer_done` is high for the one cycle after the clock edge that samples the final acknowledge, and `busy` is low in that same cycle.
- R8: On completion, `stat_tc` becomes 1, `intr_code` becomes 8'h10 (bus service), and `seq_step`, `fifo_flags` and `cnt_value` all become 0.
- R9: Completion is deferred in one case: `rem_size` was not negative, `cmd_phase` was low, and the remaining size is still above zero once the burst ends. The block then stays busy without `xfer_done` until a `chunk_arrive` pulse, and completes in the cycle after that pulse.
- R10: A start while busy, and a byte acknowledge while idle, have no effect on `burst_len`, `busy`, `xfer_done` or the status outputs.
- R11: A start whose burst length is zero completes at once. `xfer_done` is high in the next cycle and `busy` stays low.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_sel | input | 3 | Register select: 0..2 count bytes, 3 sequence step, 4 FIFO flags |
| reg_wdata | input | 8 | Register write data |
| start | input | 1 | Start a transfer |
| cmd_phase | input | 1 | Command phase: burst capped at 32 |
| rem_size | input | 25 | Signed remaining phase size; negative means toward the device |
| byte_ack | input | 1 | One byte moved by the DMA engine |
| chunk_arrive | input | 1 | Next data chunk from the device is available |
| burst_len | output | 24 | Burst length latched at start |
| to_device | output | 1 | Direction latched at start |
| busy | output | 1 | Transfer in progress or waiting for data |
| xfer_done | output | 1 | One-cycle completion pulse |
| cnt_value | output | 24 | Stored transfer count |
| stat_tc | output | 1 | Transfer-complete status bit |
| intr_code | output | 8 | Interrupt code |
| seq_step | output | 3 | Sequence step |
| fifo_flags | output | 5 | FIFO flags |

## Verification
The hardest state to reach from the ports is the deferred wait. It needs a transfer from the device whose count is smaller than the remaining size, followed by a full burst of acknowledges. The stimulus gets there both ways. Directed cases pair a small count with a large positive size, including the 65536-byte case from a zero count. Random cases draw small remaining sizes against counts that are sometimes tiny, so some bursts end short of the phase. A start pulse is injected in the middle of some bursts, and an acknowledge is pulsed while the block is idle, to show that both are ignored.

// File: rtl/xfer_len_pkg.sv
// Shared constants and types for the transfer length controller.
package xfer_len_pkg;
    localparam logic [7:0] INTR_BUS_SERVICE = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/xfer_len_calc.sv
// Burst length calculator.
// Works out the burst length as the minimum of the effective count and a limit.
// The limit is the command cap in the command phase, and the magnitude of the
// signed remaining size otherwise. The sign of that size gives the direction.
// Assumes ZERO_COUNT < 2**CNT_W. Purely combinational.
module xfer_len_calc #(
    parameter int CNT_W      = 24,
    parameter int SIZE_W     = 25,
    parameter int CMD_LIMIT  = 32,
    parameter int ZERO_COUNT = 65536
) (
    input  logic [CNT_W-1:0]         count,
    input  logic                     cmd,
    input  logic signed [SIZE_W-1:0] rem_size,
    output logic [CNT_W-1:0]         burst,
    output logic [SIZE_W-1:0]        mag,
    output logic                     to_dev
);
    localparam int WIDE = ((CNT_W > SIZE_W) ? CNT_W : SIZE_W) + 1;

    logic signed [WIDE-1:0] rem_ext;
    logic [WIDE-1:0]        mag_w;
    logic [WIDE-1:0]        eff;
    logic [WIDE-1:0]        lim;
    logic [WIDE-1:0]        pick;

    // Size magnitude, effective count, limit and minimum.
    always_comb begin
        rem_ext = WIDE'(rem_size);
        to_dev  = rem_size[SIZE_W-1];
        mag_w   = to_dev ? $unsigned(-rem_ext) : $unsigned(rem_ext);
        mag     = mag_w[SIZE_W-1:0];
        eff     = (count == '0) ? WIDE'(ZERO_COUNT) : WIDE'(count);
        lim     = cmd ? WIDE'(CMD_LIMIT) : mag_w;
        pick    = (eff < lim) ? eff : lim;
        burst   = pick[CNT_W-1:0];
    end
endmodule

// File: rtl/xfer_byte_counter.sv
// Burst down-counter and completion sequencer.
// Loads the burst and the size magnitude on launch, and counts both down on each
// acknowledge. It raises finish on the final acknowledge, or on a chunk arrival
// once completion has been deferred. Assumes launch only arrives while idle.
module xfer_byte_counter
    import xfer_len_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int SIZE_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [CNT_W-1:0]  burst_init,
    input  logic [SIZE_W-1:0] mag_init,
    input  logic              may_defer,
    input  logic              ack,
    input  logic              chunk,
    output logic              busy,
    output logic              finish
);
    xfer_state_e       state;
    logic [CNT_W-1:0]  burst_rem;
    logic [SIZE_W-1:0] mag_rem;
    logic              defer_q;
    logic              last_ack;
    logic [SIZE_W-1:0] mag_after;
    logic              go_wait;

    // Decode the final acknowledge and whether completion must wait.
    always_comb begin
        last_ack  = (state == ST_RUN) && ack && (burst_rem == CNT_W'(1));
        mag_after = (mag_rem == '0) ? '0 : mag_rem - SIZE_W'(1);
        go_wait   = defer_q && (mag_after != '0);
        finish    = (launch && (burst_init == '0))
                  || (last_ack && !go_wait)
                  || ((state == ST_WAIT) && chunk);
        busy      = (state != ST_IDLE);
    end

    // State, burst remainder and size remainder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            burst_rem <= '0;
            mag_rem   <= '0;
            defer_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        burst_rem <= burst_init;
                        mag_rem   <= mag_init;
                        defer_q   <= may_defer;
                        state     <= (burst_init == '0) ? ST_IDLE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (ack) begin
                        burst_rem <= burst_rem - CNT_W'(1);
                        mag_rem   <= mag_after;
                        if (burst_rem == CNT_W'(1))
                            state <= go_wait ? ST_WAIT : ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (chunk) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R7: a running burst never holds a zero remainder.
    p_run_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (burst_rem != '0));

    // R9: the deferred wait holds until a chunk arrives.
    p_wait_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAIT) && !chunk) |=> (state == ST_WAIT));

    // R10: nothing moves the remainder while idle without a launch.
    p_idle_ack_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !launch) |=> $stable(burst_rem));
endmodule

// File: rtl/xfer_status_regs.sv
// Count bytes, sequence step, FIFO flags and completion status.
// Byte-wide writes select a count byte by index; the next two indices select the
// sequence step and the flags. Completion wins over a write in the same cycle.
module xfer_status_regs
    import xfer_len_pkg::*;
#(
    parameter int CNT_BYTES = 3,
    parameter int SEL_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [SEL_W-1:0]       reg_sel,
    input  logic [7:0]             reg_wdata,
    input  logic                   launch,
    input  logic                   finish,
    output logic [8*CNT_BYTES-1:0] count,
    output logic                   stat_tc,
    output logic [7:0]             intr_code,
    output logic [2:0]             seq_step,
    output logic [4:0]             fifo_flags
);
    localparam logic [SEL_W-1:0] SEL_SEQ   = SEL_W'(CNT_BYTES);
    localparam logic [SEL_W-1:0] SEL_FLAGS = SEL_W'(CNT_BYTES + 1);

    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt_byte
        logic [7:0] byte_q;
        // One count byte: cleared on completion, else loaded by its write.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  byte_q <= '0;
            else if (finish)                             byte_q <= '0;
            else if (reg_wr && (reg_sel == SEL_W'(g)))   byte_q <= reg_wdata;
        end
        assign count[g*8 +: 8] = byte_q;
    end

    // Sequence step and FIFO flags: written by software, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_step   <= '0;
            fifo_flags <= '0;
        end else if (finish) begin
            seq_step   <= '0;
            fifo_flags <= '0;
        end else if (reg_wr) begin
            if (reg_sel == SEL_SEQ)   seq_step   <= reg_wdata[2:0];
            if (reg_sel == SEL_FLAGS) fifo_flags <= reg_wdata[4:0];
        end
    end

    // Transfer-complete bit and interrupt code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_tc   <= 1'b0;
            intr_code <= '0;
        end else if (finish) begin
            stat_tc   <= 1'b1;
            intr_code <= INTR_BUS_SERVICE;
        end else if (launch) begin
            stat_tc   <= 1'b0;
        end
    end

    // R8: completion leaves the status and the cleared registers as required.
    p_finish_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> (stat_tc && (intr_code == INTR_BUS_SERVICE) && (count == '0)
                    && (seq_step == '0) && (fifo_flags == '0)));

    // R6: a launch that does not finish at once clears the complete bit.
    p_launch_clears_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !finish) |=> !stat_tc);
endmodule

// File: rtl/xfer_len_ctrl.sv
// Transfer length controller, top level.
// Gates start to the idle state, latches the burst length and direction, and
// turns the completion event into a one-cycle pulse. Assumes byte_ack and
// chunk_arrive are single-cycle pulses from the DMA side.
module xfer_len_ctrl #(
    parameter int CNT_BYTES  = 3,
    parameter int SIZE_W     = 25,
    parameter int CMD_LIMIT  = 32,
    parameter int ZERO_COUNT = 65536,
    parameter int SEL_W      = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [SEL_W-1:0]         reg_sel,
    input  logic [7:0]               reg_wdata,
    input  logic                     start,
    input  logic                     cmd_phase,
    input  logic signed [SIZE_W-1:0] rem_size,
    input  logic                     byte_ack,
    input  logic                     chunk_arrive,
    output logic [8*CNT_BYTES-1:0]   burst_len,
    output logic                     to_device,
    output logic                     busy,
    output logic                     xfer_done,
    output logic [8*CNT_BYTES-1:0]   cnt_value,
    output logic                     stat_tc,
    output logic [7:0]               intr_code,
    output logic [2:0]               seq_step,
    output logic [4:0]               fifo_flags
);
    localparam int CNT_W = 8 * CNT_BYTES;

    logic [CNT_W-1:0]  calc_burst;
    logic [SIZE_W-1:0] calc_mag;
    logic              calc_to_dev;
    logic              launch;
    logic              finish;

    assign launch = start && !busy;

    xfer_len_calc #(
        .CNT_W(CNT_W), .SIZE_W(SIZE_W),
        .CMD_LIMIT(CMD_LIMIT), .ZERO_COUNT(ZERO_COUNT)
    ) calc_i (
        .count(cnt_value), .cmd(cmd_phase), .rem_size(rem_size),
        .burst(calc_burst), .mag(calc_mag), .to_dev(calc_to_dev)
    );

    xfer_byte_counter #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .burst_init(calc_burst), .mag_init(calc_mag),
        .may_defer(!cmd_phase && !calc_to_dev),
        .ack(byte_ack), .chunk(chunk_arrive),
        .busy(busy), .finish(finish)
    );

    xfer_status_regs #(.CNT_BYTES(CNT_BYTES), .SEL_W(SEL_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .launch(launch), .finish(finish),
        .count(cnt_value), .stat_tc(stat_tc), .intr_code(intr_code),
        .seq_step(seq_step), .fifo_flags(fifo_flags)
    );

    // Latch burst length and direction at launch; register the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_len <= '0;
            to_device <= 1'b0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= finish;
            if (launch) begin
                burst_len <= calc_burst;
                to_device <= calc_to_dev;
            end
        end
    end

    // R7: the done pulse never overlaps a busy transfer.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !busy);

    // R10: a start while busy leaves the latched burst alone.
    p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(burst_len));

    // R3: a command-phase launch never latches more than the cap.
    p_cmd_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && cmd_phase) |=> (burst_len <= (8*CNT_BYTES)'(CMD_LIMIT)));
endmodule

// File: tb/xfer_len_ctrl_tb_top.sv
module xfer_len_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr;
    logic [2:0]         reg_sel;
    logic [7:0]         reg_wdata;
    logic               start;
    logic               cmd_phase;
    logic signed [24:0] rem_size;
    logic               byte_ack;
    logic               chunk_arrive;
    logic [23:0]        burst_len;
    logic               to_device;
    logic               busy;
    logic               xfer_done;
    logic [23:0]        cnt_value;
    logic               stat_tc;
    logic [7:0]         intr_code;
    logic [2:0]         seq_step;
    logic [4:0]         fifo_flags;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_len_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .start(start), .cmd_phase(cmd_phase),
        .rem_size(rem_size), .byte_ack(byte_ack), .chunk_arrive(chunk_arrive),
        .burst_len(burst_len), .to_device(to_device), .busy(busy),
        .xfer_done(xfer_done), .cnt_value(cnt_value), .stat_tc(stat_tc),
        .intr_code(intr_code), .seq_step(seq_step), .fifo_flags(fifo_flags)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint f_burst(input longint cnt, input bit cmd, input longint rem);
        longint eff = (cnt == 0) ? 65536 : cnt;
        longint lim = cmd ? 32 : ((rem < 0) ? -rem : rem);
        return (eff < lim) ? eff : lim;
    endfunction

    function automatic bit f_defer(input bit cmd, input longint rem, input longint b);
        return !cmd && (rem >= 0) && (rem - b > 0);
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic run_xfer(input longint cnt, input bit cmd, input longint rem,
                            input bit gaps, input bit inject);
        longint b = f_burst(cnt, cmd, rem);
        bit     dfr = f_defer(cmd, rem, b);
        string  tag = cmd ? "R3" : ((rem < 0) ? "R4" : "R5");
        wr(3'd0, 8'(cnt));
        wr(3'd1, 8'(cnt >> 8));
        wr(3'd2, 8'(cnt >> 16));
        check(cnt_value == 24'(cnt), "R1", cnt_value, cnt);
        wr(3'd3, 8'h05);
        wr(3'd4, 8'h1a);
        cmd_phase = cmd; rem_size = 25'(rem); start = 1'b1;
        tick();
        start = 1'b0;
        if (b == 0) begin
            check(xfer_done && !busy && stat_tc, "R11", {xfer_done, busy, stat_tc}, 3'b101);
        end else begin
            check(burst_len == 24'(b), (cnt == 0) ? "R2" : tag, burst_len, b);
            check(to_device == (rem < 0), (rem < 0) ? "R4" : "R5", to_device, (rem < 0));
            check(busy && !stat_tc && !xfer_done, "R6", {busy, stat_tc, xfer_done}, 3'b100);
            for (longint n = 0; n < b; n++) begin
                if (inject && n == 0) begin
                    cmd_phase = ~cmd; rem_size = -25'sd3; start = 1'b1;
                    tick();
                    start = 1'b0; cmd_phase = cmd; rem_size = 25'(rem);
                    check(burst_len == 24'(b) && busy, "R10", burst_len, b);
                end
                if (gaps && ($urandom % 4 == 0)) tick();
                byte_ack = 1'b1;
                tick();
                byte_ack = 1'b0;
            end
            if (dfr) begin
                check(busy && !xfer_done, "R9", {busy, xfer_done}, 2'b10);
                repeat (3) tick();
                check(busy && !xfer_done && !stat_tc, "R9", {busy, xfer_done, stat_tc}, 3'b100);
                chunk_arrive = 1'b1;
                tick();
                chunk_arrive = 1'b0;
                check(xfer_done && !busy, "R9", {xfer_done, busy}, 2'b10);
            end else begin
                check(xfer_done && !busy, "R7", {xfer_done, busy}, 2'b10);
            end
        end
        check(stat_tc && intr_code == 8'h10, "R8", {stat_tc, intr_code}, 9'h110);
        check(seq_step == 0 && fifo_flags == 0 && cnt_value == 0, "R8",
              {seq_step, fifo_flags, cnt_value}, 0);
        tick();
        check(!xfer_done, "R7", xfer_done, 0);
    endtask

    initial begin
        void'($urandom(32'd7));
        rst_n = 1'b0; reg_wr = 0; reg_sel = 0; reg_wdata = 0; start = 0;
        cmd_phase = 0; rem_size = 0; byte_ack = 0; chunk_arrive = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check(!busy && !xfer_done && !stat_tc && intr_code == 0 && burst_len == 0
              && cnt_value == 0 && seq_step == 0 && fifo_flags == 0 && !to_device,
              "R12", {busy, xfer_done, stat_tc}, 0);

        run_xfer(0, 1'b0, 70000, 1'b0, 1'b0);     // R2 and R9: 65536 from zero count, deferred
        run_xfer(0, 1'b1, 9, 1'b0, 1'b0);         // R2 and R3: zero count in command phase
        run_xfer(5, 1'b0, -100, 1'b1, 1'b1);      // R4: toward device, no deferral
        run_xfer(1000, 1'b0, 0, 1'b0, 1'b0);      // R11: zero burst
        run_xfer(10, 1'b0, 10, 1'b0, 1'b0);       // R5: exact fit, no deferral
        run_xfer(3, 1'b0, 50, 1'b1, 1'b1);        // R9: deferral with a start injected
        run_xfer(24'h123456, 1'b0, -40, 1'b0, 1'b0); // R1 and R4

        // R10: an acknowledge while idle changes nothing visible.
        byte_ack = 1'b1;
        tick();
        byte_ack = 1'b0;
        check(!busy && !xfer_done && stat_tc && cnt_value == 0, "R10",
              {busy, xfer_done, stat_tc}, 3'b001);

        for (int i = 0; i < 30; i++) begin
            longint c;
            longint r;
            case ($urandom % 3)
                0: c = longint'($urandom % 24'hffffff);
                1: c = longint'($urandom_range(8));
                default: c = 0;
            endcase
            r = longint'($urandom_range(160)) - 80;
            run_xfer(c, 1'($urandom % 2), r, 1'b1, 1'($urandom % 3 == 0));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule